// File: doc/BRIEF.md
# Runahead Speculative Store Cache

This block is a small set-associative buffer for store data that a core produces while it runs ahead past a long-latency miss. Stores in this mode never reach the L1 data cache. They land here instead, so that later loads in the same runahead episode can see the values those stores wrote. A load probes this block and the L1 data cache in the same cycle. The block merges its own bytes over the L1 line that the core feeds back, and it marks the result unusable when any requested byte came from a register whose value was not known.

The block is a scratch area only. A line that is replaced is dropped and written nowhere. A store whose address could not be computed is discarded. When the core leaves runahead mode, a single flush empties the whole structure. Addresses on both ports are line addresses, meaning byte address bits above the 3-bit line offset. Store data and byte enables are lane-aligned to the 8-byte line.

Top module: `runahead_store_cache`

## Requirements
- R1: A store with `st_valid` and `st_addr_ok` high is written at the next clock edge. A later load of the same line asserts `ld_hit` and returns the stored bytes. Line address bits [3:0] select one of 16 sets and bits [28:4] form the tag.
- R2: A load that matches no valid line returns `ld_hit`=0, `ld_data` equal to `l1_data`, and `ld_inv`=0.
- R3: On a hit, byte lane b of `ld_data` comes from this cache if any store since allocation wrote lane b. Otherwise it comes from lane b of `l1_data`.
- R4: A store with `st_addr_ok` low changes no entry, no data and no replacement state.
- R5: A store with `st_inv`=1 marks its enabled bytes invalid, and a later store with `st_inv`=0 to those bytes makes them valid again. `ld_inv` is 1 exactly when the load hits and some byte selected by `ld_be` (bit b for lane b) is written and marked invalid.
- R6: Each set holds 4 lines. Storing a fifth distinct tag into a full set replaces one line, and that line's data is lost, so a later load of it misses.
- R7: The replaced line is the one in its set whose most recent store is oldest. Empty ways are filled before any valid line is replaced, lowest way first.
- R8: `flush` empties every line at the next clock edge. A store presented in the same cycle as `flush` is dropped.
- R9: Lookup is combinational: a store written at one edge is visible to a load in the following cycle.
- R10: After reset no line is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty all lines (runahead exit) |
| st_valid | input | 1 | Runahead store present |
| st_addr_ok | input | 1 | Store address was computed (known) |
| st_line_addr | input | 29 | Store line address |
| st_data | input | 64 | Lane-aligned store data |
| st_be | input | 8 | Store byte enables per lane |
| st_inv | input | 1 | Store data came from an unknown register |
| ld_valid | input | 1 | Runahead load lookup present |
| ld_line_addr | input | 29 | Load line address |
| ld_be | input | 8 | Load byte lanes requested |
| l1_data | input | 64 | L1 line read in the same cycle, for merging |
| ld_hit | output | 1 | Load matched a line here |
| ld_data | output | 64 | Merged load data |
| ld_inv | output | 1 | Load result is unknown |

## Verification
The assertions check several properties on every cycle:
- a lookup never matches more than one way;
- the valid bits stay unchanged unless a store is written or a flush arrives;
- a flush empties every line;
- a written way becomes most recently used;
- a missing load passes the L1 line through with a clear invalid flag;
- an invalid result always implies a hit;
- a store is visible one cycle later.

Only the bench's scenarios can show the rest:
- the exact byte merge over `l1_data`;
- setting and clearing of the per-byte invalid marks;
- that an ignored store leaves data intact;
- which line is chosen as victim, and that its data is lost;
- that a store beside a flush is dropped.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
    localparam int LA_W   = 29;
    localparam int LINE_B = 8;
    localparam int SETS   = 16;
    localparam int WAYS   = 4;

    localparam int DATA_W = LINE_B * 8;
    localparam int SET_W  = $clog2(SETS);
    localparam int TAG_W  = LA_W - SET_W;
    localparam int WAY_W  = $clog2(WAYS);

    typedef logic [SET_W-1:0]  set_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [WAY_W-1:0]  way_t;
    typedef logic [LINE_B-1:0] bmask_t;
    typedef logic [DATA_W-1:0] line_t;
    typedef logic [WAYS-1:0]   wvec_t;

    typedef struct packed {
        tag_t tag;
        set_t set;
    } laddr_t;

    typedef struct packed {
        line_t  data;
        bmask_t wmask;
        bmask_t imask;
    } entry_t;

    function automatic laddr_t split_line(input logic [LA_W-1:0] a);
        return laddr_t'(a);
    endfunction

    function automatic line_t merge_bytes(input line_t base, input line_t upd, input bmask_t sel);
        line_t r;
        r = base;
        for (int b = 0; b < LINE_B; b++)
            if (sel[b]) r[b*8 +: 8] = upd[b*8 +: 8];
        return r;
    endfunction

    function automatic way_t lowest_way(input wvec_t v);
        way_t r;
        r = '0;
        for (int w = WAYS - 1; w >= 0; w--)
            if (v[w]) r = way_t'(w);
        return r;
    endfunction
endpackage

// File: rtl/rsc_tag_array.sv
module rsc_tag_array
    import rsc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  set_t  ld_set,
    input  tag_t  ld_tag,
    output wvec_t ld_match,
    input  set_t  st_set,
    input  tag_t  st_tag,
    output wvec_t st_match,
    output wvec_t st_valid_ways,
    input  logic  wr_en,
    input  way_t  wr_way
);
    logic [SETS-1:0][WAYS-1:0] valid_q;
    tag_t tag_q [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (rst || flush)
            valid_q <= '0;
        else if (wr_en)
            valid_q[st_set][wr_way] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en)
            tag_q[st_set][wr_way] <= st_tag;
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign ld_match[w] = valid_q[ld_set][w] && (tag_q[ld_set][w] == ld_tag);
        assign st_match[w] = valid_q[st_set][w] && (tag_q[st_set][w] == st_tag);
    end
    assign st_valid_ways = valid_q[st_set];

    // R1
    single_match_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ld_match) && $onehot0(st_match));

    // R4
    valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !flush) |=> (valid_q == $past(valid_q)));

    // R8
    flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_q == '0));
endmodule

// File: rtl/rsc_lru.sv
module rsc_lru
    import rsc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  touch,
    input  set_t  set,
    input  way_t  way,
    input  wvec_t valid,
    output way_t  victim
);
    logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] age_q;
    logic [WAYS-1:0][WAY_W-1:0] cur;
    way_t oldest;

    assign cur = age_q[set];

    always_comb begin
        oldest = '0;
        for (int w = 0; w < WAYS; w++)
            if (cur[w] == WAY_W'(WAYS - 1)) oldest = way_t'(w);
    end

    assign victim = (&valid) ? oldest : lowest_way(~valid);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w] <= WAY_W'(w);
        end else if (touch) begin
            for (int w = 0; w < WAYS; w++) begin
                if (way_t'(w) == way)
                    age_q[set][w] <= '0;
                else if (cur[w] < cur[way])
                    age_q[set][w] <= cur[w] + 1'b1;
            end
        end
    end

    logic t_q;
    set_t t_set_q;
    way_t t_way_q;
    always_ff @(posedge clk) begin
        t_q     <= touch && !rst;
        t_set_q <= set;
        t_way_q <= way;
    end

    // R7
    touched_newest_chk: assert property (@(posedge clk) disable iff (rst)
        t_q |-> (age_q[t_set_q][t_way_q] == '0));
endmodule

// File: rtl/rsc_data_array.sv
module rsc_data_array
    import rsc_pkg::*;
(
    input  logic   clk,
    input  logic   wr_en,
    input  logic   alloc,
    input  set_t   wr_set,
    input  way_t   wr_way,
    input  line_t  wdata,
    input  bmask_t wbe,
    input  logic   winv,
    input  set_t   rd_set,
    input  way_t   rd_way,
    output entry_t rd_entry
);
    entry_t mem_q [SETS][WAYS];
    entry_t old_e, new_e;
    bmask_t inv_bits;

    assign old_e    = mem_q[wr_set][wr_way];
    assign inv_bits = winv ? wbe : '0;

    always_comb begin
        new_e.data = merge_bytes(old_e.data, wdata, wbe);
        if (alloc) begin
            new_e.wmask = wbe;
            new_e.imask = inv_bits;
        end else begin
            new_e.wmask = old_e.wmask | wbe;
            new_e.imask = (old_e.imask & ~wbe) | inv_bits;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en)
            mem_q[wr_set][wr_way] <= new_e;
    end

    assign rd_entry = mem_q[rd_set][rd_way];
endmodule

// File: rtl/runahead_store_cache.sv
module runahead_store_cache
    import rsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              st_valid,
    input  logic              st_addr_ok,
    input  logic [LA_W-1:0]   st_line_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic [LINE_B-1:0] st_be,
    input  logic              st_inv,
    input  logic              ld_valid,
    input  logic [LA_W-1:0]   ld_line_addr,
    input  logic [LINE_B-1:0] ld_be,
    input  logic [DATA_W-1:0] l1_data,
    output logic              ld_hit,
    output logic [DATA_W-1:0] ld_data,
    output logic              ld_inv
);
    laddr_t st_a, ld_a;
    wvec_t  ld_match, st_match, st_valid_ways;
    way_t   victim, wr_way;
    logic   st_hit, wr_en;
    entry_t rd_e;

    assign st_a   = split_line(st_line_addr);
    assign ld_a   = split_line(ld_line_addr);
    assign wr_en  = st_valid && st_addr_ok && !flush;
    assign st_hit = |st_match;
    assign wr_way = st_hit ? lowest_way(st_match) : victim;

    rsc_tag_array u_tags (
        .clk(clk), .rst(rst), .flush(flush),
        .ld_set(ld_a.set), .ld_tag(ld_a.tag), .ld_match(ld_match),
        .st_set(st_a.set), .st_tag(st_a.tag), .st_match(st_match),
        .st_valid_ways(st_valid_ways), .wr_en(wr_en), .wr_way(wr_way)
    );

    rsc_lru u_lru (
        .clk(clk), .rst(rst), .touch(wr_en), .set(st_a.set), .way(wr_way),
        .valid(st_valid_ways), .victim(victim)
    );

    rsc_data_array u_data (
        .clk(clk), .wr_en(wr_en), .alloc(!st_hit), .wr_set(st_a.set),
        .wr_way(wr_way), .wdata(st_data), .wbe(st_be), .winv(st_inv),
        .rd_set(ld_a.set), .rd_way(lowest_way(ld_match)), .rd_entry(rd_e)
    );

    always_comb begin
        ld_hit = ld_valid && (|ld_match);
        if (ld_hit) begin
            ld_data = merge_bytes(l1_data, rd_e.data, rd_e.wmask);
            ld_inv  = |(ld_be & rd_e.wmask & rd_e.imask);
        end else begin
            ld_data = l1_data;
            ld_inv  = 1'b0;
        end
    end

    // R2
    miss_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        !ld_hit |-> (ld_data == l1_data && !ld_inv));

    // R5
    inv_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
        ld_inv |-> ld_hit);

    // R9
    store_visible_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((ld_valid && ld_line_addr == $past(st_line_addr)) |-> ld_hit));
endmodule

// File: tb/sim_runahead_store_cache.sv
module sim_runahead_store_cache;
    import rsc_pkg::*;

    logic clk = 0, rst = 1, flush = 0;
    logic st_valid = 0, st_addr_ok = 0, st_inv = 0, ld_valid = 0;
    logic [LA_W-1:0] st_line_addr = '0, ld_line_addr = '0;
    logic [63:0] st_data = '0, l1_data = 64'hDEAD_BEEF_0BAD_F00D;
    logic [7:0] st_be = '0, ld_be = '0;
    logic ld_hit, ld_inv;
    logic [63:0] ld_data;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    runahead_store_cache u0 (.*);

    localparam logic [63:0] L1 = 64'hDEAD_BEEF_0BAD_F00D;

    typedef struct packed {
        logic [1:0]  op;      // 0 store, 1 store with unknown address, 2 load
        logic [28:0] la;
        logic [63:0] data;
        logic [7:0]  be;
        logic        inv;
        logic        e_hit;
        logic [63:0] e_data;
        logic        e_inv;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t TBL [12] = '{
        '{2'd2, 29'h20, 64'h0, 8'hFF, 1'b0, 1'b0, L1, 1'b0, 4'd2},                                  // R2 miss
        '{2'd0, 29'h20, 64'h1111_2222_3333_4444, 8'h0F, 1'b0, 1'b0, 64'h0, 1'b0, 4'd1},             // R1 store
        '{2'd2, 29'h20, 64'h0, 8'hFF, 1'b0, 1'b1, 64'hDEAD_BEEF_3333_4444, 1'b0, 4'd3},             // R3 merge
        '{2'd0, 29'h20, 64'h5555_6666_0000_0000, 8'hF0, 1'b1, 1'b0, 64'h0, 1'b0, 4'd5},             // R5 inv store
        '{2'd2, 29'h20, 64'h0, 8'hFF, 1'b0, 1'b1, 64'h5555_6666_3333_4444, 1'b1, 4'd5},             // R5 inv seen
        '{2'd2, 29'h20, 64'h0, 8'h0F, 1'b0, 1'b1, 64'h5555_6666_3333_4444, 1'b0, 4'd5},             // R5 clean lanes
        '{2'd1, 29'h20, 64'h9999_9999_9999_9999, 8'hFF, 1'b0, 1'b0, 64'h0, 1'b0, 4'd4},             // R4 ignored
        '{2'd2, 29'h20, 64'h0, 8'hFF, 1'b0, 1'b1, 64'h5555_6666_3333_4444, 1'b1, 4'd4},             // R4 unchanged
        '{2'd0, 29'h20, 64'h7777_8888_0000_0000, 8'hF0, 1'b0, 1'b0, 64'h0, 1'b0, 4'd5},             // R5 clear inv
        '{2'd2, 29'h20, 64'h0, 8'hFF, 1'b0, 1'b1, 64'h7777_8888_3333_4444, 1'b0, 4'd5},             // R5 cleared
        '{2'd1, 29'h41, 64'h1234, 8'hFF, 1'b0, 1'b0, 64'h0, 1'b0, 4'd4},                            // R4 ignored
        '{2'd2, 29'h41, 64'h0, 8'hFF, 1'b0, 1'b0, L1, 1'b0, 4'd4}                                   // R4 no alloc
    };

    task automatic do_store(input logic [28:0] la, input logic [63:0] d, input logic [7:0] be,
                            input logic inv, input logic ok);
        @(negedge clk);
        st_valid = 1; st_addr_ok = ok; st_line_addr = la; st_data = d; st_be = be; st_inv = inv;
        @(negedge clk);
        st_valid = 0; st_addr_ok = 0;
    endtask

    task automatic check_load(input string rq, input logic [28:0] la, input logic [7:0] be,
                              input logic eh, input logic [63:0] ed, input logic ei);
        @(negedge clk);
        ld_valid = 1; ld_line_addr = la; ld_be = be;
        #2;
        n_chk++;
        if (ld_hit !== eh) begin
            n_fail++;
            $display("FAIL %s hit line %h: got %b expected %b", rq, la, ld_hit, eh);
        end
        n_chk++;
        if (ld_data !== ed) begin
            n_fail++;
            $display("FAIL %s data line %h: got %h expected %h", rq, la, ld_data, ed);
        end
        n_chk++;
        if (ld_inv !== ei) begin
            n_fail++;
            $display("FAIL %s inv line %h: got %b expected %b", rq, la, ld_inv, ei);
        end
        ld_valid = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R10 reset state: lines in two sets are empty
        check_load("R10", 29'h20, 8'hFF, 1'b0, L1, 1'b0);
        check_load("R10", 29'h101, 8'hFF, 1'b0, L1, 1'b0);

        for (int i = 0; i < 12; i++) begin
            if (TBL[i].op == 2'd2)
                check_load($sformatf("R%0d", TBL[i].req), TBL[i].la, TBL[i].be,
                           TBL[i].e_hit, TBL[i].e_data, TBL[i].e_inv);
            else
                do_store(TBL[i].la, TBL[i].data, TBL[i].be, TBL[i].inv, TBL[i].op == 2'd0);
        end

        // R9 store visible in the very next cycle
        @(negedge clk);
        st_valid = 1; st_addr_ok = 1; st_line_addr = 29'h30; st_data = {8{8'h33}}; st_be = 8'hFF; st_inv = 0;
        @(negedge clk);
        st_valid = 0; st_addr_ok = 0;
        ld_valid = 1; ld_line_addr = 29'h30; ld_be = 8'hFF;
        #2;
        n_chk++;
        if (ld_hit !== 1'b1 || ld_data !== {8{8'h33}}) begin
            n_fail++;
            $display("FAIL R9 next-cycle hit: got %b/%h expected 1/%h", ld_hit, ld_data, {8{8'h33}});
        end
        ld_valid = 0;

        // R6 R7 fill set 0, refresh tag 2, then a fifth tag replaces tag 3
        do_store(29'h40, {8{8'h44}}, 8'hFF, 1'b0, 1'b1);
        do_store(29'h50, {8{8'h55}}, 8'hFF, 1'b0, 1'b1);
        do_store(29'h20, 64'h44, 8'h01, 1'b0, 1'b1);
        do_store(29'h60, {8{8'h66}}, 8'hFF, 1'b0, 1'b1);
        check_load("R7", 29'h30, 8'hFF, 1'b0, L1, 1'b0);
        check_load("R6", 29'h40, 8'hFF, 1'b1, {8{8'h44}}, 1'b0);
        check_load("R6", 29'h50, 8'hFF, 1'b1, {8{8'h55}}, 1'b0);
        check_load("R7", 29'h20, 8'hFF, 1'b1, 64'h7777_8888_3333_4444, 1'b0);
        check_load("R6", 29'h60, 8'hFF, 1'b1, {8{8'h66}}, 1'b0);

        // R8 flush with a same-cycle store
        @(negedge clk);
        flush = 1; st_valid = 1; st_addr_ok = 1; st_line_addr = 29'h101; st_data = '1; st_be = 8'hFF;
        @(negedge clk);
        flush = 0; st_valid = 0; st_addr_ok = 0;
        check_load("R8", 29'h20, 8'hFF, 1'b0, L1, 1'b0);
        check_load("R8", 29'h60, 8'hFF, 1'b0, L1, 1'b0);
        check_load("R8", 29'h101, 8'hFF, 1'b0, L1, 1'b0);
        do_store(29'h60, {8{8'hA6}}, 8'hFF, 1'b1, 1'b1);
        check_load("R8", 29'h60, 8'h80, 1'b1, {8{8'hA6}}, 1'b1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule